// File: doc/BRIEF.md
# Configurable CPU Board Address Decoder

This block sits between an 8-bit CPU and its memory. It takes byte or 16-bit word accesses on a 16-bit address bus and sends each byte cycle to one of four places: a small on-board scratch RAM, a low EPROM window, a boot/monitor ROM, or an external backplane. The top address nibble selects a 4 KB page. Four jumper-style configuration inputs decide how some pages are routed: RAM enable, low-EPROM enable, high-EPROM option and monitor mirror. When the monitor mirror is on, the top of the boot ROM also appears in the highest page, so the reset and interrupt vectors are visible there.

The requester uses a valid/ready handshake. A byte access takes one byte cycle. A word access takes two byte cycles on consecutive clocks, big-endian: the high byte is at the given address and the low byte at the next address. After the last byte cycle, `done` pulses for one clock, together with the assembled read data. Reads and writes decode differently. Writes reach only the on-board RAM or the backplane. The ROM pages are never write targets. Each device is a byte port whose read data is valid in the same cycle as its select strobe. A separate output gives the base address at which the EPROM bank is decoded.

Top module: `cpu_board_decoder`

## Requirements
- R1: With cfg_ram_en=1, a read or write in page 0xA (addr[15:12]=4'hA) goes to the RAM port with offset addr[6:0], so the 128-byte RAM repeats across the page. A write pulses ram_sel and ram_we together.
- R2: With cfg_ram_en=0, reads and writes in page 0xA go to the backplane with the full 16-bit address.
- R3: A read in page 0xC goes to the EPROM port with offset addr-0xC000 (addr[11:0]) when cfg_lo_prom_en=1. When cfg_lo_prom_en=0 it returns 8'hFF and no device strobe is asserted.
- R4: A read in page 0xE always goes to the boot ROM port with offset (addr-0xE000) modulo ROM capacity (2**ROM_AW bytes).
- R5: A read in page 0xF goes to the boot ROM with offset (addr-(0x10000-capacity)) modulo capacity when cfg_mon_en=1. When cfg_mon_en=0 it goes to the backplane.
- R6: A read in any other page (0x0-0x9, 0xB, 0xD) goes to the backplane with the full address, and the backplane byte is returned unchanged.
- R7: Every write that does not go to the RAM under R1 goes to the backplane with bp_we=1, including writes to pages 0xC, 0xE and 0xF.
- R8: A word read returns {byte(addr), byte(addr+1)}, where addr+1 wraps modulo 2**16. Each byte is routed on its own by R1-R6.
- R9: A word write sends wdata[15:8] to addr in the first byte cycle and wdata[7:0] to addr+1 in the next cycle. Each byte is routed on its own.
- R10: req_ready is high only when the block is idle. done is high for exactly one cycle: 2 cycles after acceptance for a byte access and 3 cycles after for a word access. A byte read returns its data in rdata[7:0] with rdata[15:8]=0.
- R11: prom_base is 16'hC000 when cfg_lo_prom_en=1, else 16'hF000 when cfg_hi_prom_en=1, else 16'h0000.
- R12: At most one of ram_sel, prom_sel, rom_sel, bp_sel is high in any cycle. None is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ram_en | input | 1 | On-board RAM enabled in page 0xA |
| cfg_lo_prom_en | input | 1 | EPROM readable in page 0xC |
| cfg_hi_prom_en | input | 1 | EPROM bank placed high (affects prom_base only) |
| cfg_mon_en | input | 1 | Boot ROM mirrored into page 0xF |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data (byte access uses [7:0]) |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |
| prom_base | output | 16 | EPROM bank base address |
| ram_sel | output | 1 | RAM byte cycle strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM byte offset |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte |
| prom_sel | output | 1 | EPROM read strobe |
| prom_addr | output | PROM_AW | EPROM byte offset |
| prom_rdata | input | 8 | EPROM read byte |
| rom_sel | output | 1 | Boot ROM read strobe |
| rom_addr | output | ROM_AW | Boot ROM byte offset |
| rom_rdata | input | 8 | Boot ROM read byte |
| bp_sel | output | 1 | Backplane byte cycle strobe |
| bp_we | output | 1 | Backplane write enable |
| bp_addr | output | 16 | Backplane address |
| bp_wdata | output | 8 | Backplane write byte |
| bp_rdata | input | 8 | Backplane read byte |

## Verification
Random byte and word accesses land in all sixteen pages, and each one is paired with a random value of the four configuration bits. This covers every page against every jumper setting, so a page that is routed to the wrong device, or that ignores its enable bit, shows up in the per-device strobe counts and in the returned byte. Each device answers with data computed from its own offset, so a wrong offset base or mirror mask produces a wrong byte rather than a plausible one. Directed word accesses straddle a page edge (0x9FFF into the RAM page, 0xFFFF wrapping to 0x0000) to confirm that the two bytes are routed separately and ordered big-endian. A RAM write through one alias followed by a read through another exposes the address mirroring.

// File: rtl/board_decoder_pkg.sv
package board_decoder_pkg;

    // Destination of one byte cycle
    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,   // unpopulated window, reads float high
        TGT_RAM  = 3'd1,
        TGT_PROM = 3'd2,
        TGT_ROM  = 3'd3,
        TGT_BP   = 3'd4
    } target_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_BYTE0 = 2'd1,
        SQ_BYTE1 = 2'd2,
        SQ_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic        write;
        logic        word;
        logic [15:0] rdata;
    } seq_regs_t;

    localparam logic [3:0]  PAGE_RAM  = 4'hA;
    localparam logic [3:0]  PAGE_PROM = 4'hC;
    localparam logic [3:0]  PAGE_ROM  = 4'hE;
    localparam logic [3:0]  PAGE_TOP  = 4'hF;

    localparam logic [16:0] BASE_RAM  = 17'h0A000;
    localparam logic [16:0] BASE_PROM = 17'h0C000;
    localparam logic [16:0] BASE_ROM  = 17'h0E000;

    localparam logic [15:0] PROM_BASE_LO = 16'hC000;
    localparam logic [15:0] PROM_BASE_HI = 16'hF000;
    localparam logic [7:0]  FLOAT_BYTE   = 8'hFF;

endpackage

// File: rtl/addr_page_decode.sv
module addr_page_decode
    import board_decoder_pkg::*;
#(
    parameter int RAM_AW  = 7,
    parameter int PROM_AW = 12,
    parameter int ROM_AW  = 11
) (
    input  logic [15:0]        addr,
    input  logic               write,
    input  logic               ram_en,
    input  logic               lo_prom_en,
    input  logic               mon_en,
    output target_e            tgt,
    output logic [RAM_AW-1:0]  ram_off,
    output logic [PROM_AW-1:0] prom_off,
    output logic [ROM_AW-1:0]  rom_off
);
    localparam logic [16:0] ROM_CAP  = 17'(1) << ROM_AW;
    localparam logic [16:0] MON_BASE = 17'h10000 - ROM_CAP;

    logic [3:0]  page;
    logic [16:0] addr_x;
    logic [16:0] ram_rel;
    logic [16:0] prom_rel;
    logic [16:0] rom_rel;
    logic [16:0] mon_rel;

    always_comb begin
        page     = addr[15:12];
        addr_x   = {1'b0, addr};
        ram_rel  = addr_x - BASE_RAM;
        prom_rel = addr_x - BASE_PROM;
        rom_rel  = addr_x - BASE_ROM;
        mon_rel  = addr_x - MON_BASE;

        ram_off  = ram_rel[RAM_AW-1:0];
        prom_off = prom_rel[PROM_AW-1:0];
        rom_off  = rom_rel[ROM_AW-1:0];
        tgt      = TGT_BP;

        if (write) begin
            // write path: only the scratch RAM is local
            if (page == PAGE_RAM && ram_en) begin
                tgt = TGT_RAM;
            end
        end else begin
            unique case (page)
                PAGE_RAM:  tgt = ram_en ? TGT_RAM : TGT_BP;
                PAGE_PROM: tgt = lo_prom_en ? TGT_PROM : TGT_NONE;
                PAGE_ROM:  tgt = TGT_ROM;
                PAGE_TOP: begin
                    if (mon_en) begin
                        tgt     = TGT_ROM;
                        rom_off = mon_rel[ROM_AW-1:0];
                    end
                end
                default:   tgt = TGT_BP;
            endcase
        end
    end

endmodule

// File: rtl/byte_port_mux.sv
module byte_port_mux
    import board_decoder_pkg::*;
#(
    parameter int RAM_AW  = 7,
    parameter int PROM_AW = 12,
    parameter int ROM_AW  = 11
) (
    input  logic               active,
    input  logic               write,
    input  target_e            tgt,
    input  logic [15:0]        addr,
    input  logic [7:0]         wbyte,
    input  logic [RAM_AW-1:0]  ram_off,
    input  logic [PROM_AW-1:0] prom_off,
    input  logic [ROM_AW-1:0]  rom_off,
    output logic [7:0]         rbyte,

    output logic               ram_sel,
    output logic               ram_we,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic [7:0]         ram_wdata,
    input  logic [7:0]         ram_rdata,
    output logic               prom_sel,
    output logic [PROM_AW-1:0] prom_addr,
    input  logic [7:0]         prom_rdata,
    output logic               rom_sel,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [7:0]         rom_rdata,
    output logic               bp_sel,
    output logic               bp_we,
    output logic [15:0]        bp_addr,
    output logic [7:0]         bp_wdata,
    input  logic [7:0]         bp_rdata
);
    always_comb begin
        ram_sel   = active && (tgt == TGT_RAM);
        prom_sel  = active && (tgt == TGT_PROM);
        rom_sel   = active && (tgt == TGT_ROM);
        bp_sel    = active && (tgt == TGT_BP);
        ram_we    = ram_sel && write;
        bp_we     = bp_sel && write;

        ram_addr  = ram_off;
        prom_addr = prom_off;
        rom_addr  = rom_off;
        bp_addr   = addr;
        ram_wdata = wbyte;
        bp_wdata  = wbyte;

        unique case (tgt)
            TGT_RAM:  rbyte = ram_rdata;
            TGT_PROM: rbyte = prom_rdata;
            TGT_ROM:  rbyte = rom_rdata;
            TGT_BP:   rbyte = bp_rdata;
            default:  rbyte = FLOAT_BYTE;
        endcase
    end

endmodule

// File: rtl/word_sequencer.sv
module word_sequencer
    import board_decoder_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic        req_word,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        done,
    output logic [15:0] rdata,
    output logic        cyc_active,
    output logic        cyc_write,
    output logic [15:0] cyc_addr,
    output logic [7:0]  cyc_wbyte,
    input  logic [7:0]  cyc_rbyte
);
    seq_regs_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        req_ready  = 1'b0;
        done       = 1'b0;
        cyc_active = 1'b0;
        cyc_write  = r_q.write;
        cyc_addr   = r_q.addr;
        cyc_wbyte  = r_q.wdata[7:0];

        unique case (r_q.state)
            SQ_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.state = SQ_BYTE0;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.write = req_write;
                    r_d.word  = req_word;
                    r_d.rdata = 16'h0000;
                end
            end
            SQ_BYTE0: begin
                cyc_active = 1'b1;
                cyc_wbyte  = r_q.word ? r_q.wdata[15:8] : r_q.wdata[7:0];
                if (!r_q.write) begin
                    if (r_q.word) r_d.rdata[15:8] = cyc_rbyte;
                    else          r_d.rdata[7:0]  = cyc_rbyte;
                end
                r_d.state = r_q.word ? SQ_BYTE1 : SQ_DONE;
            end
            SQ_BYTE1: begin
                cyc_active = 1'b1;
                cyc_addr   = r_q.addr + 16'd1;
                cyc_wbyte  = r_q.wdata[7:0];
                if (!r_q.write) r_d.rdata[7:0] = cyc_rbyte;
                r_d.state = SQ_DONE;
            end
            default: begin
                done      = 1'b1;
                r_d.state = SQ_IDLE;
            end
        endcase
        rdata = r_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: SQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/cpu_board_decoder.sv
module cpu_board_decoder
    import board_decoder_pkg::*;
#(
    parameter int RAM_AW  = 7,
    parameter int PROM_AW = 12,
    parameter int ROM_AW  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_ram_en,
    input  logic               cfg_lo_prom_en,
    input  logic               cfg_hi_prom_en,
    input  logic               cfg_mon_en,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_word,
    input  logic [15:0]        req_addr,
    input  logic [15:0]        req_wdata,
    output logic               done,
    output logic [15:0]        rdata,
    output logic [15:0]        prom_base,
    output logic               ram_sel,
    output logic               ram_we,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic [7:0]         ram_wdata,
    input  logic [7:0]         ram_rdata,
    output logic               prom_sel,
    output logic [PROM_AW-1:0] prom_addr,
    input  logic [7:0]         prom_rdata,
    output logic               rom_sel,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [7:0]         rom_rdata,
    output logic               bp_sel,
    output logic               bp_we,
    output logic [15:0]        bp_addr,
    output logic [7:0]         bp_wdata,
    input  logic [7:0]         bp_rdata
);
    logic               cyc_active;
    logic               cyc_write;
    logic [15:0]        cyc_addr;
    logic [7:0]         cyc_wbyte;
    logic [7:0]         cyc_rbyte;
    target_e            cyc_tgt;
    logic [RAM_AW-1:0]  cyc_ram_off;
    logic [PROM_AW-1:0] cyc_prom_off;
    logic [ROM_AW-1:0]  cyc_rom_off;

    word_sequencer i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_word   (req_word),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .done       (done),
        .rdata      (rdata),
        .cyc_active (cyc_active),
        .cyc_write  (cyc_write),
        .cyc_addr   (cyc_addr),
        .cyc_wbyte  (cyc_wbyte),
        .cyc_rbyte  (cyc_rbyte)
    );

    addr_page_decode #(
        .RAM_AW  (RAM_AW),
        .PROM_AW (PROM_AW),
        .ROM_AW  (ROM_AW)
    ) i_dec (
        .addr       (cyc_addr),
        .write      (cyc_write),
        .ram_en     (cfg_ram_en),
        .lo_prom_en (cfg_lo_prom_en),
        .mon_en     (cfg_mon_en),
        .tgt        (cyc_tgt),
        .ram_off    (cyc_ram_off),
        .prom_off   (cyc_prom_off),
        .rom_off    (cyc_rom_off)
    );

    byte_port_mux #(
        .RAM_AW  (RAM_AW),
        .PROM_AW (PROM_AW),
        .ROM_AW  (ROM_AW)
    ) i_mux (
        .active     (cyc_active),
        .write      (cyc_write),
        .tgt        (cyc_tgt),
        .addr       (cyc_addr),
        .wbyte      (cyc_wbyte),
        .ram_off    (cyc_ram_off),
        .prom_off   (cyc_prom_off),
        .rom_off    (cyc_rom_off),
        .rbyte      (cyc_rbyte),
        .ram_sel    (ram_sel),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_rdata  (ram_rdata),
        .prom_sel   (prom_sel),
        .prom_addr  (prom_addr),
        .prom_rdata (prom_rdata),
        .rom_sel    (rom_sel),
        .rom_addr   (rom_addr),
        .rom_rdata  (rom_rdata),
        .bp_sel     (bp_sel),
        .bp_we      (bp_we),
        .bp_addr    (bp_addr),
        .bp_wdata   (bp_wdata),
        .bp_rdata   (bp_rdata)
    );

    // EPROM bank placement, low window wins over high option
    always_comb begin
        if (cfg_lo_prom_en)      prom_base = PROM_BASE_LO;
        else if (cfg_hi_prom_en) prom_base = PROM_BASE_HI;
        else                     prom_base = 16'h0000;
    end

endmodule

// File: rtl/board_decoder_checker.sv
module board_decoder_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_ram_en,
    input logic cfg_lo_prom_en,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic ram_sel,
    input logic ram_we,
    input logic prom_sel,
    input logic rom_sel,
    input logic bp_sel,
    input logic bp_we
);
    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, prom_sel, rom_sel, bp_sel}));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(ram_sel || prom_sel || rom_sel || bp_sel));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !done));

    assert_ready_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && done));

    assert_ram_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> cfg_ram_en);

    assert_ram_we_framed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_sel);

    assert_prom_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prom_sel |-> cfg_lo_prom_en);

    assert_bp_we_framed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bp_we |-> bp_sel);

endmodule

bind cpu_board_decoder board_decoder_checker i_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_ram_en     (cfg_ram_en),
    .cfg_lo_prom_en (cfg_lo_prom_en),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .done           (done),
    .ram_sel        (ram_sel),
    .ram_we         (ram_we),
    .prom_sel       (prom_sel),
    .rom_sel        (rom_sel),
    .bp_sel         (bp_sel),
    .bp_we          (bp_we)
);

// File: tb/test_cpu_board_decoder.sv
module test_cpu_board_decoder;
    localparam int RAM_AW  = 7;
    localparam int PROM_AW = 12;
    localparam int ROM_AW  = 11;
    localparam int ROM_CAP = 1 << ROM_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic               cfg_ram_en = 0, cfg_lo_prom_en = 0, cfg_hi_prom_en = 0, cfg_mon_en = 0;
    logic               req_valid = 0, req_write = 0, req_word = 0;
    logic [15:0]        req_addr = 0, req_wdata = 0;
    logic               req_ready, done;
    logic [15:0]        rdata, prom_base;
    logic               ram_sel, ram_we, prom_sel, rom_sel, bp_sel, bp_we;
    logic [RAM_AW-1:0]  ram_addr;
    logic [PROM_AW-1:0] prom_addr;
    logic [ROM_AW-1:0]  rom_addr;
    logic [15:0]        bp_addr;
    logic [7:0]         ram_wdata, bp_wdata, ram_rdata, prom_rdata, rom_rdata, bp_rdata;

    cpu_board_decoder #(.RAM_AW(RAM_AW), .PROM_AW(PROM_AW), .ROM_AW(ROM_AW)) i_cpu_board_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_ram_en(cfg_ram_en), .cfg_lo_prom_en(cfg_lo_prom_en),
        .cfg_hi_prom_en(cfg_hi_prom_en), .cfg_mon_en(cfg_mon_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .prom_base(prom_base),
        .ram_sel(ram_sel), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .prom_sel(prom_sel), .prom_addr(prom_addr), .prom_rdata(prom_rdata),
        .rom_sel(rom_sel), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .bp_sel(bp_sel), .bp_we(bp_we), .bp_addr(bp_addr),
        .bp_wdata(bp_wdata), .bp_rdata(bp_rdata)
    );

    // ---------------- behavioural devices ----------------
    function automatic logic [7:0] prom_fn(input logic [PROM_AW-1:0] o);
        return o[7:0] ^ {o[11:8], o[11:8]} ^ 8'hA5;
    endfunction
    function automatic logic [7:0] rom_fn(input logic [ROM_AW-1:0] o);
        logic [15:0] t;
        t = 16'(o) * 16'd3;
        return t[7:0] ^ {5'd0, o[10:8]} ^ 8'h11;
    endfunction
    function automatic logic [7:0] bp_fn(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    logic [7:0] ram_mem [128];
    logic [7:0] shadow  [128];
    assign ram_rdata  = ram_mem[ram_addr];
    assign prom_rdata = prom_fn(prom_addr);
    assign rom_rdata  = rom_fn(rom_addr);
    assign bp_rdata   = bp_fn(bp_addr);

    // free-running strobe counters and a backplane write log
    int n_ram = 0, n_prom = 0, n_rom = 0, n_bp = 0, n_log = 0;
    logic [15:0] log_a [8];
    logic [7:0]  log_d [8];
    always @(posedge clk) begin
        if (ram_sel) n_ram <= n_ram + 1;
        if (prom_sel) n_prom <= n_prom + 1;
        if (rom_sel) n_rom <= n_rom + 1;
        if (bp_sel) n_bp <= n_bp + 1;
        if (ram_sel && ram_we) ram_mem[ram_addr] <= ram_wdata;
        if (bp_sel && bp_we) begin
            log_a[n_log % 8] <= bp_addr;
            log_d[n_log % 8] <= bp_wdata;
            n_log <= n_log + 1;
        end
    end

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    // 0 none, 1 ram, 2 prom, 3 rom, 4 backplane
    function automatic int route(input logic [15:0] a, input bit wr, input logic [3:0] c);
        logic [3:0] pg;
        pg = a[15:12];
        if (wr) return (pg == 4'hA && c[0]) ? 1 : 4;
        case (pg)
            4'hA: return c[0] ? 1 : 4;
            4'hC: return c[1] ? 2 : 0;
            4'hE: return 3;
            4'hF: return c[3] ? 3 : 4;
            default: return 4;
        endcase
    endfunction

    function automatic string req_tag(input logic [15:0] a, input bit wr, input logic [3:0] c);
        if (wr) return (a[15:12] == 4'hA && c[0]) ? "R1" : "R7";
        case (a[15:12])
            4'hA: return c[0] ? "R1" : "R2";
            4'hC: return "R3";
            4'hE: return "R4";
            4'hF: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic [3:0] c);
        int r;
        int off;
        r = route(a, 0, c);
        case (r)
            1: return shadow[a[6:0]];
            2: return prom_fn(PROM_AW'(int'(a) - 'hC000));
            3: begin
                if (a[15:12] == 4'hE) off = (int'(a) - 'hE000) % ROM_CAP;
                else off = (int'(a) - ('h10000 - ROM_CAP)) % ROM_CAP;
                return rom_fn(ROM_AW'(off));
            end
            4: return bp_fn(a);
            default: return 8'hFF;
        endcase
    endfunction

    task automatic xact(input bit wr, input bit wd, input logic [15:0] a,
                        input logic [15:0] d, input logic [3:0] c);
        int e_cnt [5];
        logic [15:0] ba [2];
        logic [7:0]  bd [2];
        logic [15:0] e_rd;
        logic [15:0] e_la [2];
        logic [7:0]  e_ld [2];
        int e_nl, s_ram, s_prom, s_rom, s_bp, s_log, lat, nb;
        string tg;
        foreach (e_cnt[k]) e_cnt[k] = 0;
        nb    = wd ? 2 : 1;
        ba[0] = a;
        ba[1] = a + 16'd1;
        bd[0] = wd ? d[15:8] : d[7:0];
        bd[1] = d[7:0];
        e_rd  = 16'h0000;
        e_nl  = 0;
        tg    = req_tag(a, wr, c);
        for (int i = 0; i < nb; i++) begin
            e_cnt[route(ba[i], wr, c)]++;
            if (!wr) begin
                if (wd && i == 0) e_rd[15:8] = exp_rd(ba[i], c);
                else              e_rd[7:0]  = exp_rd(ba[i], c);
            end else if (route(ba[i], 1, c) == 1) begin
                shadow[ba[i][6:0]] = bd[i];
            end else begin
                e_la[e_nl] = ba[i];
                e_ld[e_nl] = bd[i];
                e_nl++;
            end
        end
        @(negedge clk);
        {cfg_mon_en, cfg_hi_prom_en, cfg_lo_prom_en, cfg_ram_en} = c;
        s_ram = n_ram; s_prom = n_prom; s_rom = n_rom; s_bp = n_bp; s_log = n_log;
        chk(req_ready, "R10", "ready before request", 32'(req_ready), 1);
        req_valid = 1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == (wd ? 3 : 2), "R10", "done latency", 32'(lat), wd ? 3 : 2);
        if (!wr) chk(rdata == e_rd, wd ? "R8" : tg, "read data", 32'(rdata), 32'(e_rd));
        chk(n_ram - s_ram == e_cnt[1], tg, "ram strobes", 32'(n_ram - s_ram), 32'(e_cnt[1]));
        chk(n_prom - s_prom == e_cnt[2], tg, "prom strobes", 32'(n_prom - s_prom), 32'(e_cnt[2]));
        chk(n_rom - s_rom == e_cnt[3], tg, "rom strobes", 32'(n_rom - s_rom), 32'(e_cnt[3]));
        chk(n_bp - s_bp == e_cnt[4], tg, "bp strobes", 32'(n_bp - s_bp), 32'(e_cnt[4]));
        if (wr) begin
            chk(n_log - s_log == e_nl, "R7", "bp write count", 32'(n_log - s_log), 32'(e_nl));
            for (int i = 0; i < e_nl && i < n_log - s_log; i++) begin
                chk(log_a[(s_log + i) % 8] == e_la[i], wd ? "R9" : "R7", "bp write addr",
                    32'(log_a[(s_log + i) % 8]), 32'(e_la[i]));
                chk(log_d[(s_log + i) % 8] == e_ld[i], wd ? "R9" : "R7", "bp write data",
                    32'(log_d[(s_log + i) % 8]), 32'(e_ld[i]));
            end
        end
        @(negedge clk);
        chk(!done && req_ready, "R10", "done single cycle", 32'({done, req_ready}), 1);
    endtask

    bit finished = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2718);
        for (int i = 0; i < 128; i++) begin
            ram_mem[i] = 8'h00;
            shadow[i]  = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R10, R12)
        chk(req_ready && !done, "R10", "reset ready/done", 32'({req_ready, done}), 2);
        chk(!(ram_sel || prom_sel || rom_sel || bp_sel), "R12", "idle strobes",
            32'({ram_sel, prom_sel, rom_sel, bp_sel}), 0);
        // prom base options (R11)
        for (int c = 0; c < 4; c++) begin
            cfg_lo_prom_en = c[0];
            cfg_hi_prom_en = c[1];
            #1;
            chk(prom_base == (c[0] ? 16'hC000 : (c[1] ? 16'hF000 : 16'h0000)), "R11",
                "prom_base", 32'(prom_base), c[0] ? 32'hC000 : (c[1] ? 32'hF000 : 0));
        end
        // directed corners
        xact(1, 0, 16'hA005, 16'h005A, 4'b0001);   // R1 write RAM
        xact(0, 0, 16'hA085, 16'h0000, 4'b0001);   // R1 mirror read
        xact(0, 0, 16'hAF85, 16'h0000, 4'b0001);   // R1 mirror far in page
        xact(1, 0, 16'hA010, 16'h0077, 4'b0000);   // R2 write to backplane
        xact(0, 0, 16'hA010, 16'h0000, 4'b0000);   // R2 read from backplane
        xact(0, 0, 16'hC123, 16'h0000, 4'b0000);   // R3 disabled window -> FF
        xact(0, 0, 16'hCFFF, 16'h0000, 4'b0010);   // R3 enabled
        xact(0, 0, 16'hE9AB, 16'h0000, 4'b0000);   // R4 boot ROM
        xact(0, 0, 16'hFFFE, 16'h0000, 4'b1000);   // R5 vectors mirrored
        xact(0, 0, 16'hFFFE, 16'h0000, 4'b0000);   // R5 mirror off -> backplane
        xact(0, 0, 16'h1234, 16'h0000, 4'b1111);   // R6
        xact(1, 0, 16'hE000, 16'h0099, 4'b1111);   // R7 ROM page write
        xact(1, 0, 16'hC000, 16'h0088, 4'b1111);   // R7 EPROM page write
        xact(1, 1, 16'hA07F, 16'hBEEF, 4'b0001);   // R9 word write into RAM
        xact(0, 1, 16'hA07F, 16'h0000, 4'b0001);   // R8 word read back (wraps mirror)
        xact(0, 1, 16'h9FFF, 16'h0000, 4'b0001);   // R8 straddles into RAM page
        xact(0, 1, 16'hFFFF, 16'h0000, 4'b1000);   // R8 address wrap
        xact(1, 1, 16'hFFFF, 16'hCAFE, 4'b0000);   // R9 write wrap
        xact(1, 1, 16'hBFFF, 16'h1357, 4'b1111);   // R9 split routing
        // random sweep over pages and configurations
        for (int n = 0; n < 800; n++) begin
            logic [15:0] a, d;
            logic [3:0]  c;
            a = 16'($urandom);
            d = 16'($urandom);
            c = 4'($urandom);
            xact(1'($urandom), 1'($urandom), a, d, c);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule